// File: doc/BRIEF.md
# SPI Octal Output Controller

This block is the logic side of an eight-channel output driver. A host programs the on/off state of the eight channels through a four-wire SPI slave, or, when the interface strap is low, the channels simply follow eight parallel input pins. A second strap chooses between short 8-bit frames that carry only channel states and long 16-bit frames that add a nibble-parity check on the way in and a diagnostic nibble on the way out.

Each transfer returns the per-channel fault flags captured at the start of the transfer. Bits shifted in on MOSI leave on MISO one frame later, so several devices can share a chip select in a chain. A global output-enable input gates all eight channels. A watchdog, counted in system clocks, clears the programmed channel states when the host stops kicking it.

All SPI and kick pins are brought into the system clock domain through two flip-flops, and edges are detected one stage later. An edge on a pin therefore takes effect on the third rising system clock edge after it. The system clock must run at least four times faster than SCK.

Top module: `spi_octal_out_ctrl`

## Requirements
- R1: After reset all channel outputs are 0, MISO is 0 and the channel latch holds 0.
- R2: With `spi_mode` low the channels follow `par_in` (gated by `out_en`), and SPI traffic leaves the channel latch untouched, so switching to SPI mode afterwards shows 0.
- R3: In SPI mode with `wide_frame` low, MOSI is sampled on rising SCK, MSB first. On the rising edge of `cs_n` the last 8 received bits are latched, the first of them driving channel 7, provided the number of SCK rises is a non-zero multiple of 8.
- R4: With `wide_frame` high, a frame is 16 bits. Bits 15:8 are channel states 7..0, bits 7:4 are ignored and bits 3:0 are check bits. The frame is accepted only if the XOR of its four nibbles is zero. A frame failing this check leaves the latch unchanged.
- R5: A transfer whose SCK rise count is zero or not a multiple of the frame length leaves the latch unchanged and sets the communication-fail flag. A later accepted frame clears the flag.
- R6: In 8-bit mode the response shifted out on MISO (changing on falling SCK) is the fault vector `ch_fault` captured when `cs_n` fell, bit 7 first.
- R7: In 16-bit mode the response is {faults[7:0], `reg_ok`, `case_hot`, comm-fail, `pwr_good`, check nibble}, MSB first. The check nibble makes the XOR of the four nibbles zero. The comm-fail bit is the flag value at the falling edge of `cs_n`.
- R8: After the first frame length of SCK edges in a transfer, MISO repeats the MOSI bits delayed by one frame length. With more than one frame in a transfer, only the last frame is latched.
- R9: With `out_en` low all channels are 0. The latch is kept and reappears when `out_en` returns high.
- R10: With `wd_en` high in SPI mode, after WD_TIMEOUT system clocks without a kick the channel latch is cleared. A clear takes priority over a latch on the same cycle.
- R11: A falling edge on `wd_kick_n` restarts the watchdog timer. With `wd_en` low the timer never clears the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode | input | 1 | Strap: 1 selects SPI control, 0 parallel pins |
| wide_frame | input | 1 | Strap: 1 selects 16-bit frames, 0 selects 8-bit frames |
| par_in | input | 8 | Parallel channel states |
| sck | input | 1 | SPI clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in |
| miso | output | 1 | SPI data out |
| out_en | input | 1 | Global output enable |
| wd_en | input | 1 | Watchdog enable |
| wd_kick_n | input | 1 | Watchdog restart, falling edge |
| ch_fault | input | 8 | Per-channel fault flags |
| reg_ok | input | 1 | Regulator status for the diagnostic nibble |
| case_hot | input | 1 | Case over-temperature for the diagnostic nibble |
| pwr_good | input | 1 | Supply good for the diagnostic nibble |
| ch_on | output | 8 | Channel drive controls |

## Verification
On every cycle the assertions check several rules. The channel latch moves only on a chip-select release or a watchdog clear. A rejected frame keeps the latch and raises the fail flag. A watchdog clear empties the latch and a kick zeroes the timer. MISO changes only on a falling SCK or a chip-select fall, and parallel mode leaves the SPI side idle. Other behaviour can be shown only by the bench's scenarios, each compared against its reference model on every clock: the bit order of the latched data, the nibble-parity decision, the content of the response frames, the one-frame delay in a chain, the edge-count rejection and the timing of the watchdog expiry.

// File: rtl/spi_octal_out_ctrl.sv
module spi_octal_out_ctrl #(
  parameter int WD_TIMEOUT = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_mode,
  input  logic       wide_frame,
  input  logic [7:0] par_in,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  input  logic       out_en,
  input  logic       wd_en,
  input  logic       wd_kick_n,
  input  logic [7:0] ch_fault,
  input  logic       reg_ok,
  input  logic       case_hot,
  input  logic       pwr_good,
  output logic [7:0] ch_on
);
  localparam int WD_W = $clog2(WD_TIMEOUT + 1);

  logic [2:0] sck_q, cs_q, kick_q;
  logic [1:0] mosi_q;
  logic [15:0] sr;
  logic [3:0] bit_cnt;
  logic got_frame, comm_fail, miso_q;
  logic [7:0] out_reg;
  logic [WD_W-1:0] wd_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= 3'b000;
      cs_q   <= 3'b111;
      kick_q <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      kick_q <= {kick_q[1:0], wd_kick_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  wire sck_rise = spi_mode & ~cs_q[1] &  sck_q[1] & ~sck_q[2];
  wire sck_fall = spi_mode & ~cs_q[1] & ~sck_q[1] &  sck_q[2];
  wire cs_fall  = spi_mode & ~cs_q[1] &  cs_q[2];
  wire cs_rise  = spi_mode &  cs_q[1] & ~cs_q[2];
  wire kick     = kick_q[2] & ~kick_q[1];

  wire [3:0] frame_last = wide_frame ? 4'd15 : 4'd7;
  wire [3:0] diag       = {reg_ok, case_hot, comm_fail, pwr_good};
  wire [3:0] resp_chk   = ch_fault[7:4] ^ ch_fault[3:0] ^ diag;
  wire       parity_ok  = ~wide_frame | ((sr[15:12] ^ sr[11:8] ^ sr[7:4] ^ sr[3:0]) == 4'd0);
  wire       frame_ok   = got_frame & (bit_cnt == 4'd0) & parity_ok;
  wire [7:0] rx_data    = wide_frame ? sr[15:8] : sr[7:0];

  wire wd_run  = spi_mode & wd_en;
  wire wd_fire = wd_run & ~kick & (wd_cnt == WD_W'(WD_TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr        <= '0;
      bit_cnt   <= '0;
      got_frame <= 1'b0;
      miso_q    <= 1'b0;
    end else if (cs_fall) begin
      sr        <= wide_frame ? {ch_fault, diag, resp_chk} : {8'h00, ch_fault};
      miso_q    <= ch_fault[7];
      bit_cnt   <= '0;
      got_frame <= 1'b0;
    end else if (sck_rise) begin
      sr      <= {sr[14:0], mosi_q[1]};
      bit_cnt <= (bit_cnt == frame_last) ? 4'd0 : bit_cnt + 4'd1;
      if (bit_cnt == frame_last) got_frame <= 1'b1;
    end else if (sck_fall) begin
      miso_q <= wide_frame ? sr[15] : sr[7];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_reg   <= '0;
      comm_fail <= 1'b0;
    end else begin
      if (wd_fire) out_reg <= '0;
      else if (cs_rise && frame_ok) out_reg <= rx_data;
      if (cs_rise) comm_fail <= ~frame_ok;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wd_cnt <= '0;
    else if (!wd_run || kick || wd_fire) wd_cnt <= '0;
    else wd_cnt <= wd_cnt + 1'b1;

  assign miso  = miso_q;
  assign ch_on = out_en ? (spi_mode ? out_reg : par_in) : 8'h00;

  assert_hold_without_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && !wd_fire) |=> $stable(out_reg));

  assert_reject_keeps_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !frame_ok && !wd_fire) |=> ($stable(out_reg) && comm_fail));

  assert_wd_clears_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> (out_reg == 8'h00));

  assert_kick_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_run && kick) |=> (wd_cnt == '0));

  assert_miso_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall) |=> $stable(miso));

  assert_parallel_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_mode |=> ($stable(out_reg) && wd_cnt == '0));
endmodule

// File: tb/spi_octal_out_ctrl_tb.sv
module spi_octal_out_ctrl_tb;
  localparam int WD_T = 500;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_mode = 1'b0, wide_frame = 1'b0, out_en = 1'b1, wd_en = 1'b0;
  logic [7:0] par_in = 8'h00, ch_fault = 8'h81;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wd_kick_n = 1'b1;
  logic reg_ok = 1'b1, case_hot = 1'b0, pwr_good = 1'b1;
  logic miso;
  logic [7:0] ch_on;

  spi_octal_out_ctrl #(.WD_TIMEOUT(WD_T)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .wide_frame(wide_frame),
    .par_in(par_in), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .out_en(out_en), .wd_en(wd_en), .wd_kick_n(wd_kick_n), .ch_fault(ch_fault),
    .reg_ok(reg_ok), .case_hot(case_hot), .pwr_good(pwr_good), .ch_on(ch_on));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model: pin history, bit queue, counters.
  logic h1s = 0, h2s = 0, h3s = 0, h1c = 1, h2c = 1, h3c = 1, h1k = 1, h2k = 1, h3k = 1, h1m = 0, h2m = 0;
  bit m_q[$];
  logic [7:0] m_out = 0;
  bit m_cf = 0;
  int m_wd = 0;
  logic [15:0] m_resp = 0;
  int m_rlen = 8;

  always @(posedge clk) begin : model
    int n, fl;
    bit ok;
    logic [15:0] fr;
    logic [3:0] d;
    if (!rst_n) begin
      m_q.delete(); m_out = 0; m_cf = 0; m_wd = 0;
      h1s = 0; h2s = 0; h3s = 0; h1c = 1; h2c = 1; h3c = 1;
      h1k = 1; h2k = 1; h3k = 1; h1m = 0; h2m = 0;
    end else begin
      if (spi_mode) begin
        if (h3c && !h2c) begin
          m_q.delete();
          d = {reg_ok, case_hot, m_cf, pwr_good};
          m_rlen = wide_frame ? 16 : 8;
          m_resp = wide_frame ? {ch_fault, d, ch_fault[7:4] ^ ch_fault[3:0] ^ d} : {8'h00, ch_fault};
        end else if (!h2c && h2s && !h3s) m_q.push_back(h2m);
        if (!h3c && h2c) begin
          n = m_q.size(); fl = wide_frame ? 16 : 8;
          ok = (n > 0) && (n % fl == 0);
          fr = 0;
          if (ok) begin
            for (int i = n - fl; i < n; i++) fr = {fr[14:0], m_q[i]};
            if (wide_frame) ok = ((fr[15:12] ^ fr[11:8] ^ fr[7:4] ^ fr[3:0]) == 4'd0);
          end
          if (ok) m_out = wide_frame ? fr[15:8] : fr[7:0];
          m_cf = !ok;
        end
      end
      if (!(spi_mode && wd_en)) m_wd = 0;
      else if (h3k && !h2k) m_wd = 0;
      else if (m_wd == WD_T - 1) begin m_out = 0; m_wd = 0; end
      else m_wd++;
      h3s = h2s; h2s = h1s; h1s = sck;
      h3c = h2c; h2c = h1c; h1c = cs_n;
      h3k = h2k; h2k = h1k; h1k = wd_kick_n;
      h2m = h1m; h1m = mosi;
    end
  end

  always @(negedge clk)
    if (rst_n && !done)
      check(cur_req, "ch_on vs model", {56'd0, ch_on},
            {56'd0, out_en ? (spi_mode ? m_out : par_in) : 8'h00});

  task automatic xfer(logic [63:0] d, int n, string req);
    logic [63:0] seen, exp;
    seen = 0; exp = 0;
    @(negedge clk) cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = d[n-1-i];
      repeat (HALF) @(negedge clk);
      seen[i] = miso;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2 * HALF) @(negedge clk);
    if (spi_mode && n > 0) begin
      for (int i = 0; i < n; i++)
        exp[i] = (i < m_rlen) ? m_resp[m_rlen-1-i] : d[n-1-(i-m_rlen)];
      check(req, "miso stream", seen, exp);
    end
  endtask

  task automatic kick_pulse();
    @(negedge clk) wd_kick_n = 0;
    repeat (4) @(negedge clk);
    wd_kick_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "reset ch_on", {56'd0, ch_on}, 64'd0);
    check("R1", "reset miso", {63'd0, miso}, 64'd0);

    cur_req = "R2";
    par_in = 8'hA5;
    @(negedge clk);
    check("R2", "parallel follow", {56'd0, ch_on}, 64'hA5);
    xfer(64'hFF, 8, "R2");
    check("R2", "parallel ignores spi", {56'd0, ch_on}, 64'hA5);
    spi_mode = 1;
    @(negedge clk);
    check("R2", "latch untouched", {56'd0, ch_on}, 64'h00);

    cur_req = "R3";
    xfer(64'h3C, 8, "R6");
    check("R3", "8-bit latch", {56'd0, ch_on}, 64'h3C);

    cur_req = "R5";
    ch_fault = 8'h4E;
    xfer(64'hFFF, 12, "R6");
    check("R5", "12 edges rejected", {56'd0, ch_on}, 64'h3C);

    cur_req = "R8";
    xfer(64'hA5C3, 16, "R8");
    check("R8", "last 8 latched", {56'd0, ch_on}, 64'hC3);

    cur_req = "R4";
    wide_frame = 1;
    xfer(64'h5A0F, 16, "R7");
    check("R4", "16-bit accept", {56'd0, ch_on}, 64'h5A);
    xfer(64'h9600, 16, "R7");
    check("R4", "bad parity rejected", {56'd0, ch_on}, 64'h5A);

    cur_req = "R8";
    case_hot = 1; reg_ok = 0;
    xfer(64'h1230_C3F0, 32, "R7");
    check("R8", "daisy last frame", {56'd0, ch_on}, 64'hC3);

    cur_req = "R5";
    xfer(64'd0, 0, "R5");
    check("R5", "zero edges rejected", {56'd0, ch_on}, 64'hC3);
    xfer(64'h1230, 16, "R5");
    check("R5", "accept after reject", {56'd0, ch_on}, 64'h12);
    xfer(64'hC3F0, 16, "R7");

    cur_req = "R9";
    out_en = 0;
    @(negedge clk);
    check("R9", "out_en low", {56'd0, ch_on}, 64'h00);
    out_en = 1;
    @(negedge clk);
    check("R9", "out_en restored", {56'd0, ch_on}, 64'hC3);

    cur_req = "R11";
    repeat (3 * WD_T) @(negedge clk);
    check("R11", "wd disabled keeps", {56'd0, ch_on}, 64'hC3);
    wd_en = 1;
    for (int k = 0; k < 6; k++) begin
      repeat (300) @(negedge clk);
      kick_pulse();
    end
    check("R11", "kicked wd keeps", {56'd0, ch_on}, 64'hC3);

    cur_req = "R10";
    repeat (WD_T + 20) @(negedge clk);
    check("R10", "wd expiry clears", {56'd0, ch_on}, 64'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog timeout in %s actual=hung expected=finish", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule